// File: doc/BRIEF.md
# External Edge-Port Interrupt Module

This block watches seven external interrupt pins and turns activity on them into one interrupt request line per pin, aimed at a downstream interrupt controller. Each pin passes through a two-flop synchronizer. Each pin can be set to one of four sense modes. In level mode an active-low level raises a request directly. In the three edge modes (rising, falling or both) an event is held in a sticky flag until software clears it.

Software sets the block up through a small register bus with four registers: a 16-bit sense-mode register, an 8-bit direction register, an 8-bit request-enable register and an 8-bit flag register. Clearing a flag takes a write of 1 to its bit. Line 0 is a reserved slot in every register and does nothing. Reads are combinational.

Top module: `xirq_edge_port`

## Requirements
- R1: After reset all four registers read 0 and every bit of `irq_req` is 0. Every line therefore starts as a level-sensed input with its request disabled.
- R2: Register select codes are 0 for sense mode, 1 for direction, 2 for enable and 3 for flag. A write with `bus_sel` and `bus_wr` high updates the selected register at the clock edge. A read returns its value in the same cycle, with the 8-bit registers in `bus_rdata[7:0]` and 0 in the upper byte.
- R3: Line n uses sense-mode bits [2n+1:2n], where 01 is rising edge. A low-to-high change on `pin_n[n]` sets flag bit n three clock edges after the pin is driven. A high-to-low change leaves the flag clear.
- R4: With sense code 10 (falling edge), a high-to-low change sets flag bit n three edges after the pin is driven. A rising change does not set it.
- R5: With sense code 11 (both edges), changes in either direction set flag bit n.
- R6: With sense code 00 (level), flag bit n reads 1 while the synchronized pin is low. With the enable bit set, `irq_req[n]` is high two edges after the pin goes low and low two edges after it returns high. Nothing is latched.
- R7: Writing 1 to flag bit n clears a latched flag. Writing 0 leaves it set.
- R8: If a detected edge on line n coincides with a write of 1 to flag bit n, the flag stays set.
- R9: `irq_req[n]` equals line n's flag or level condition ANDed with enable bit n. A flag still latches while the enable bit is 0, and setting the enable bit afterwards raises the request in the next cycle.
- R10: A 1 in direction bit n marks the line as an output. The line then sets no flag, and its level condition is never reported.
- R11: Line 0 is reserved. Bit 0 of the direction, enable and flag registers and bits [1:0] of the sense-mode register read 0 whatever is written, `pin_n[0]` has no effect and `irq_req[0]` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select (0 mode, 1 direction, 2 enable, 3 flag) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, 0 when not selected |
| pin_n | input | 8 | External interrupt pins, active low, bit 0 unused |
| irq_req | output | 8 | Per-line request toward the interrupt controller |

## Verification
A pin change driven before a clock edge reaches the synchronizer output after two edges. In level mode the request follows at that point. In an edge mode the flag is registered one edge later, so the bench checks one edge before the result is due, expecting the old value, and then on the due edge, expecting the new one. Register writes and enable changes show up on reads and on `irq_req` in the cycle after the write edge. The coincident-clear case times the write strobe to land on the exact edge where the second edge is detected. All inputs change on the falling clock edge, and all sampling happens there too.

// File: rtl/xep_pkg.sv
package xep_pkg;
    localparam int unsigned XEP_LINES = 8;

    typedef enum logic [1:0] {
        SENSE_LEVEL = 2'b00,
        SENSE_RISE  = 2'b01,
        SENSE_FALL  = 2'b10,
        SENSE_BOTH  = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_ENA  = 2'd2,
        SEL_FLAG = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/xep_sync.sv
module xep_sync #(
    parameter int unsigned W    = 8,
    parameter logic        IDLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] cur;
        logic [W-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = raw_i;
        s_d.cur  = s_q.meta;
        s_d.prev = s_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= {(3*W){IDLE}};
        else        s_q <= s_d;
    end

    assign cur_o  = s_q.cur;
    assign prev_o = s_q.prev;
endmodule

// File: rtl/xep_detect.sv
module xep_detect
    import xep_pkg::*;
#(
    parameter int unsigned LINES = XEP_LINES,
    localparam int unsigned MW   = 2 * LINES
) (
    input  logic [LINES-1:0] cur_i,
    input  logic [LINES-1:0] prev_i,
    input  logic [LINES-1:0] dir_i,
    input  logic [MW-1:0]    mode_i,
    output logic [LINES-1:0] edge_o,
    output logic [LINES-1:0] level_o,
    output logic [LINES-1:0] latch_o
);
    localparam logic [LINES-1:0] LIVE = {{(LINES-1){1'b1}}, 1'b0};

    logic [LINES-1:0] edge_raw, level_raw, latch_raw;

    for (genvar n = 0; n < LINES; n++) begin : g_line
        sense_e sense;
        logic   rise, fall;
        assign sense        = sense_e'(mode_i[2*n +: 2]);
        assign rise         = cur_i[n] & ~prev_i[n];
        assign fall         = ~cur_i[n] & prev_i[n];
        assign edge_raw[n]  = ((sense == SENSE_RISE) & rise)
                            | ((sense == SENSE_FALL) & fall)
                            | ((sense == SENSE_BOTH) & (rise | fall));
        assign level_raw[n] = (sense == SENSE_LEVEL) & ~cur_i[n];
        assign latch_raw[n] = (sense != SENSE_LEVEL);
    end

    // only inputs detect; line 0 is reserved
    assign edge_o  = edge_raw  & ~dir_i & LIVE;
    assign level_o = level_raw & ~dir_i & LIVE;
    assign latch_o = latch_raw & LIVE;
endmodule

// File: rtl/xep_regs.sv
module xep_regs
    import xep_pkg::*;
#(
    parameter int unsigned LINES = XEP_LINES,
    localparam int unsigned DW   = 2 * LINES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [LINES-1:0] edge_i,
    input  logic [LINES-1:0] level_i,
    input  logic [LINES-1:0] latch_i,
    output logic [DW-1:0]    mode_o,
    output logic [LINES-1:0] dir_o,
    output logic [LINES-1:0] irq_o
);
    localparam logic [LINES-1:0] LIVE      = {{(LINES-1){1'b1}}, 1'b0};
    localparam logic [DW-1:0]    MODE_LIVE = {{(DW-2){1'b1}}, 2'b00};

    typedef struct packed {
        logic [DW-1:0]    mode;
        logic [LINES-1:0] dir;
        logic [LINES-1:0] ena;
        logic [LINES-1:0] flag;
    } regs_t;

    regs_t r_d, r_q;
    logic             wr_en, wr_flag;
    logic [LINES-1:0] clr, status;
    reg_sel_e         sel;

    assign sel     = reg_sel_e'(bus_addr);
    assign wr_en   = bus_sel & bus_wr;
    assign wr_flag = wr_en & (sel == SEL_FLAG);

    always_comb begin
        r_d = r_q;
        clr = '0;
        if (wr_en) begin
            unique case (sel)
                SEL_MODE: r_d.mode = bus_wdata & MODE_LIVE;
                SEL_DIR:  r_d.dir  = bus_wdata[LINES-1:0] & LIVE;
                SEL_ENA:  r_d.ena  = bus_wdata[LINES-1:0] & LIVE;
                SEL_FLAG: clr      = bus_wdata[LINES-1:0] & LIVE;
                default:  ;
            endcase
        end
        // a fresh edge outranks a clear; level-sensed lines latch nothing
        r_d.flag = ((r_q.flag & ~clr) | edge_i) & latch_i & LIVE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign status = (r_q.flag & latch_i) | level_i;
    assign irq_o  = status & r_q.ena;
    assign mode_o = r_q.mode;
    assign dir_o  = r_q.dir;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            unique case (sel)
                SEL_MODE: bus_rdata = r_q.mode;
                SEL_DIR:  bus_rdata = {{(DW-LINES){1'b0}}, r_q.dir};
                SEL_ENA:  bus_rdata = {{(DW-LINES){1'b0}}, r_q.ena};
                SEL_FLAG: bus_rdata = {{(DW-LINES){1'b0}}, status};
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R11
    reserved_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o[0] && !r_q.flag[0]);

    for (genvar n = 1; n < LINES; n++) begin : g_chk
        // R7
        w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_flag && bus_wdata[n] && !edge_i[n]) |=> !r_q.flag[n]);
        // R8
        clear_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_flag && bus_wdata[n] && edge_i[n] && latch_i[n]) |=> r_q.flag[n]);
        // R3
        flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(r_q.flag[n]) |-> $past(edge_i[n]));
        // R10
        output_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            r_q.dir[n] |-> (!edge_i[n] && !level_i[n]));
        // R9
        enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[n] |-> r_q.ena[n]);
    end
endmodule

// File: rtl/xirq_edge_port.sv
module xirq_edge_port
    import xep_pkg::*;
#(
    parameter int unsigned LINES = XEP_LINES,
    localparam int unsigned DW   = 2 * LINES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [LINES-1:0] pin_n,
    output logic [LINES-1:0] irq_req
);
    logic [LINES-1:0] cur, prev, dir, edge_evt, level_act, latch_mode;
    logic [DW-1:0]    mode;

    xep_sync #(.W(LINES), .IDLE(1'b1)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_n),
        .cur_o  (cur),
        .prev_o (prev)
    );

    xep_detect #(.LINES(LINES)) u_detect (
        .cur_i   (cur),
        .prev_i  (prev),
        .dir_i   (dir),
        .mode_i  (mode),
        .edge_o  (edge_evt),
        .level_o (level_act),
        .latch_o (latch_mode)
    );

    xep_regs #(.LINES(LINES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .edge_i    (edge_evt),
        .level_i   (level_act),
        .latch_i   (latch_mode),
        .mode_o    (mode),
        .dir_o     (dir),
        .irq_o     (irq_req)
    );

    // R5
    edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_evt != '0) |-> (cur != prev));
endmodule

// File: tb/xirq_edge_port_tb.sv
module xirq_edge_port_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  pin_n = 8'hFF;
    logic [7:0]  irq_req;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xirq_edge_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_n(pin_n), .irq_req(irq_req)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic clean_regs();
        pin_n = 8'hFF;
        wait_cyc(3);
        bus_write(2'd2, 16'h0000);
        bus_write(2'd1, 16'h0000);
        bus_write(2'd0, 16'h0000);
        bus_write(2'd3, 16'h00FF);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int a = 0; a < 4; a++) begin
            bus_read(a[1:0], v);
            chk("R1 reg after reset", v, 16'h0000);
        end
        chk("R1 irq_req after reset", {8'h00, irq_req}, 16'h0000);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        bus_write(2'd0, 16'hFFFF);
        bus_read(2'd0, v);  chk("R2 R11 mode readback", v, 16'hFFFC);
        bus_write(2'd0, 16'h5A6B);
        bus_read(2'd0, v);  chk("R2 mode pattern", v, 16'h5A68);
        bus_write(2'd1, 16'hFFFF);
        bus_read(2'd1, v);  chk("R2 R11 dir readback", v, 16'h00FE);
        bus_write(2'd2, 16'h00A5);
        bus_read(2'd2, v);  chk("R2 R11 enable readback", v, 16'h00A4);
        clean_regs();
    endtask

    task automatic t_rise();
        logic [15:0] v;
        bus_write(2'd0, 16'h0040);       // line 3 rising
        bus_write(2'd2, 16'h0008);
        pin_n[3] = 1'b0; wait_cyc(4);
        bus_read(2'd3, v); chk("R3 falling ignored", v, 16'h0000);
        pin_n[3] = 1'b1; wait_cyc(2);
        bus_read(2'd3, v); chk("R3 flag not yet", v, 16'h0000);
        wait_cyc(1);
        bus_read(2'd3, v); chk("R3 flag set", v, 16'h0008);
        chk("R3 R9 request", {8'h00, irq_req}, 16'h0008);
        wait_cyc(3);
        bus_write(2'd3, 16'h0000);
        bus_read(2'd3, v); chk("R7 write 0 keeps flag", v, 16'h0008);
        bus_write(2'd3, 16'h0008);
        bus_read(2'd3, v); chk("R7 write 1 clears flag", v, 16'h0000);
        chk("R7 request drops", {8'h00, irq_req}, 16'h0000);
        clean_regs();
    endtask

    task automatic t_fall();
        logic [15:0] v;
        bus_write(2'd0, 16'h0800);       // line 5 falling
        pin_n[5] = 1'b0; wait_cyc(3);
        bus_read(2'd3, v); chk("R4 fall sets flag", v, 16'h0020);
        bus_write(2'd3, 16'h0020);
        pin_n[5] = 1'b1; wait_cyc(4);
        bus_read(2'd3, v); chk("R4 rising ignored", v, 16'h0000);
        clean_regs();
    endtask

    task automatic t_both();
        logic [15:0] v;
        bus_write(2'd0, 16'hC000);       // line 7 both
        pin_n[7] = 1'b0; wait_cyc(3);
        bus_read(2'd3, v); chk("R5 fall sets flag", v, 16'h0080);
        bus_write(2'd3, 16'h0080);
        bus_read(2'd3, v); chk("R5 cleared", v, 16'h0000);
        pin_n[7] = 1'b1; wait_cyc(3);
        bus_read(2'd3, v); chk("R5 rise sets flag", v, 16'h0080);
        pin_n[7] = 1'b0; wait_cyc(2);
        bus_write(2'd3, 16'h0080);       // lands on the detect edge
        bus_read(2'd3, v); chk("R8 edge beats clear", v, 16'h0080);
        bus_write(2'd3, 16'h0080);
        bus_read(2'd3, v); chk("R8 later clear works", v, 16'h0000);
        clean_regs();
    endtask

    task automatic t_level();
        logic [15:0] v;
        bus_write(2'd2, 16'h0004);       // line 2 level (mode 00)
        pin_n[2] = 1'b0; wait_cyc(1);
        chk("R6 request not yet", {8'h00, irq_req}, 16'h0000);
        wait_cyc(1);
        chk("R6 request follows low", {8'h00, irq_req}, 16'h0004);
        bus_read(2'd3, v); chk("R6 flag shows level", v, 16'h0004);
        pin_n[2] = 1'b1; wait_cyc(2);
        chk("R6 request released", {8'h00, irq_req}, 16'h0000);
        bus_read(2'd3, v); chk("R6 nothing latched", v, 16'h0000);
        clean_regs();
    endtask

    task automatic t_enable();
        logic [15:0] v;
        bus_write(2'd0, 16'h0100);       // line 4 rising, disabled
        pin_n[4] = 1'b0; wait_cyc(3);
        pin_n[4] = 1'b1; wait_cyc(3);
        bus_read(2'd3, v); chk("R9 flag latches while disabled", v, 16'h0010);
        chk("R9 no request while disabled", {8'h00, irq_req}, 16'h0000);
        bus_write(2'd2, 16'h0010);
        chk("R9 request after enable", {8'h00, irq_req}, 16'h0010);
        clean_regs();
    endtask

    task automatic t_dir();
        logic [15:0] v;
        bus_write(2'd1, 16'h0040);       // line 6 output
        bus_write(2'd2, 16'h0040);
        bus_write(2'd0, 16'h3000);       // line 6 both
        pin_n[6] = 1'b0; wait_cyc(4);
        bus_read(2'd3, v); chk("R10 output line no flag", v, 16'h0000);
        bus_write(2'd0, 16'h0000);       // level
        chk("R10 output line no level request", {8'h00, irq_req}, 16'h0000);
        bus_write(2'd1, 16'h0000);
        chk("R10 input again gives request", {8'h00, irq_req}, 16'h0040);
        clean_regs();
    endtask

    task automatic t_line0();
        logic [15:0] v;
        bus_write(2'd2, 16'h00FF);
        bus_write(2'd0, 16'h0003);
        pin_n[0] = 1'b0; wait_cyc(3);
        pin_n[0] = 1'b1; wait_cyc(3);
        pin_n[0] = 1'b0; wait_cyc(3);
        chk("R11 irq_req bit 0 stays low", {8'h00, irq_req}, 16'h0000);
        bus_read(2'd3, v); chk("R11 flag bit 0 reads 0", v, 16'h0000);
        clean_regs();
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_regs();
        t_rise();
        t_fall();
        t_both();
        t_level();
        t_enable();
        t_dir();
        t_line0();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule